// File: doc/BRIEF.md
# Far-Call Pair Fusion Detector

This decode-stage block looks at two adjacent 32-bit instruction slots each cycle. It detects the far-call idiom: an upper-immediate-to-PC add into the return-address register `x1`, followed at once by a register-indirect jump-and-link whose source and destination are both `x1`. Because the intermediate write to `x1` is overwritten by the jump's own link write, the pair has no extra visible effect. The two instructions then collapse into one direct-call micro-op. That micro-op carries the full 32-bit target, the link value, the destination register and a push-only return-stack hint.

When the pair does not qualify, the first slot passes through alone and the second is left for the next cycle. A combinational take count tells the fetch queue how many slots were consumed: 2 for a fused pair, 1 for a single instruction, 0 when nothing is valid. For a jump in the first slot that passes through, the block also classifies the return-stack action from its register fields. Outputs are registered one cycle after the slots are presented.

Top module: `rvfuse_call`

## Requirements
- R1: After reset, `out_valid` and `out_fused` are 0, and `take` is 0 while `slot0_valid` is 0.
- R2: If slot0 holds opcode 0010111 with rd (bits 11:7) = 1, and slot1 holds opcode 1100111 with funct3 (bits 14:12) = 0 and rs1 (bits 19:15) = rd = 1, and both slots are valid, `take` is 2 in the same cycle and `out_fused` and `out_valid` are 1 in the next cycle.
- R3: The fused target is slot0 PC + (slot0 bits 31:12 shifted left by 12) + sign-extended slot1 bits 31:20, with bit 0 forced to 0.
- R4: A fused micro-op reports link value = slot0 PC + 8 and destination register 1.
- R5: A fused micro-op asserts the push hint and not the pop hint.
- R6: The pair is not fused when the first instruction writes a register other than 1 (for example x7 followed by a jump with rd 1, rs1 7), when the jump's rs1 or rd is not 1 (including both 5), or when the jump's funct3 is nonzero. In these cases `take` is 1.
- R7: No fusion occurs when `slot1_valid` is 0 or `slot0_exc` is 1. `out_exc` reports the slot0 exception flag one cycle later.
- R8: An unfused slot0 is output unchanged: `out_insn` and `out_pc` equal its word and PC, `out_link` is PC + 4, `out_rd` is its bits 11:7, and `out_target` is 0.
- R9: An unfused slot0 jump with opcode 1100111 gives return-stack hints, where a link register is x1 or x5. Neither link gives none. Only rs1 a link gives pop. Only rd a link gives push. Both links but different gives push and pop. Both the same link gives push only.
- R10: An unfused slot0 jump with opcode 1101111 gives push when rd is x1 or x5, and no hint otherwise. Any other opcode gives no hint.
- R11: When `slot0_valid` is 0, `take` is 0 and `out_valid` is 0 the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot0_valid | input | 1 | First slot holds an instruction |
| slot0_insn | input | 32 | First instruction word |
| slot0_pc | input | 32 | PC of the first instruction |
| slot0_exc | input | 1 | First instruction carries a pending exception |
| slot1_valid | input | 1 | Second slot holds an instruction |
| slot1_insn | input | 32 | Second instruction word |
| take | output | 2 | Slots consumed this cycle (0, 1 or 2) |
| out_valid | output | 1 | Registered micro-op valid |
| out_fused | output | 1 | Micro-op is a fused far call |
| out_insn | output | 32 | Word of the passed-through instruction |
| out_pc | output | 32 | PC of the micro-op |
| out_exc | output | 1 | Exception flag of the micro-op |
| out_target | output | 32 | Fused call target, 0 when unfused |
| out_link | output | 32 | Link value written to the destination |
| out_rd | output | 5 | Destination register |
| out_ras_push | output | 1 | Return-stack push hint |
| out_ras_pop | output | 1 | Return-stack pop hint |

## Verification
The hardest cases to reach are near-misses: pairs that differ from the fusable idiom in a single field. Examples are the older scratch-register call, a pair built on x5, a jump with a nonzero funct3, and an otherwise perfect pair with a pending exception or an invalid second slot. Each must fall back to single-slot pass-through. The stimulus builds instruction words from field-level helper functions, so each near-miss differs from the fusable pair in exactly one field. It also runs the fused path with a negative low immediate, so the borrow into the upper part and the cleared bit 0 are both exercised.

// File: rtl/rvfuse_pkg.sv
package rvfuse_pkg;
  localparam int XLEN  = 32;
  localparam int REG_W = 5;

  localparam logic [6:0] OP_AUIPC = 7'b0010111;
  localparam logic [6:0] OP_JALR  = 7'b1100111;
  localparam logic [6:0] OP_JAL   = 7'b1101111;

  typedef struct packed {
    logic              is_auipc;
    logic              is_jalr;
    logic              is_jal;
    logic [REG_W-1:0]  rd;
    logic [REG_W-1:0]  rs1;
    logic [19:0]       imm_u;
    logic [11:0]       imm_i;
  } dec_t;

  typedef struct packed {
    logic push;
    logic pop;
  } ras_hint_t;
endpackage

// File: rtl/rvfuse_decode.sv
module rvfuse_decode
  import rvfuse_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  always_comb begin
    dec.is_auipc = (insn[6:0] == OP_AUIPC);
    dec.is_jalr  = (insn[6:0] == OP_JALR) && (insn[14:12] == 3'b000);
    dec.is_jal   = (insn[6:0] == OP_JAL);
    dec.rd       = insn[11:7];
    dec.rs1      = insn[19:15];
    dec.imm_u    = insn[31:12];
    dec.imm_i    = insn[31:20];
  end
endmodule

// File: rtl/rvfuse_match.sv
module rvfuse_match
  import rvfuse_pkg::*;
#(
  parameter int CALL_REG = 1
) (
  input  dec_t            dec0,
  input  dec_t            dec1,
  input  logic            valid0,
  input  logic            valid1,
  input  logic            exc0,
  input  logic [XLEN-1:0] pc0,
  output logic            fuse,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] link
);
  localparam logic [REG_W-1:0] CALL_R = REG_W'(CALL_REG);

  logic            shape_ok;
  logic            regs_ok;
  logic [XLEN-1:0] upper;
  logic [XLEN-1:0] lower;
  logic [XLEN-1:0] sum;

  always_comb begin
    shape_ok = dec0.is_auipc && dec1.is_jalr;
    regs_ok  = (dec0.rd == CALL_R) && (dec1.rs1 == CALL_R) && (dec1.rd == CALL_R);
    fuse     = valid0 && valid1 && !exc0 && shape_ok && regs_ok;
    upper    = {dec0.imm_u, 12'h000};
    lower    = {{(XLEN-12){dec1.imm_i[11]}}, dec1.imm_i};
    sum      = pc0 + upper + lower;
    target   = {sum[XLEN-1:1], 1'b0};
    link     = pc0 + XLEN'(8);
  end
endmodule

// File: rtl/rvfuse_ras.sv
module rvfuse_ras
  import rvfuse_pkg::*;
#(
  parameter int LINK_A = 1,
  parameter int LINK_B = 5
) (
  input  dec_t      dec,
  input  logic      fuse,
  output ras_hint_t hint
);
  localparam logic [REG_W-1:0] LA = REG_W'(LINK_A);
  localparam logic [REG_W-1:0] LB = REG_W'(LINK_B);

  logic rd_link;
  logic rs_link;

  always_comb begin
    rd_link = (dec.rd == LA) || (dec.rd == LB);
    rs_link = (dec.rs1 == LA) || (dec.rs1 == LB);
    hint    = '0;
    if (fuse) begin
      hint.push = 1'b1;
    end else if (dec.is_jalr) begin
      hint.push = rd_link;
      hint.pop  = rs_link && (!rd_link || (dec.rd != dec.rs1));
    end else if (dec.is_jal) begin
      hint.push = rd_link;
    end
  end
endmodule

// File: rtl/rvfuse_call.sv
module rvfuse_call
  import rvfuse_pkg::*;
#(
  parameter int CALL_REG    = 1,
  parameter int LINK_A      = 1,
  parameter int LINK_B      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slot0_valid,
  input  logic [31:0] slot0_insn,
  input  logic [31:0] slot0_pc,
  input  logic        slot0_exc,
  input  logic        slot1_valid,
  input  logic [31:0] slot1_insn,
  output logic [1:0]  take,
  output logic        out_valid,
  output logic        out_fused,
  output logic [31:0] out_insn,
  output logic [31:0] out_pc,
  output logic        out_exc,
  output logic [31:0] out_target,
  output logic [31:0] out_link,
  output logic [4:0]  out_rd,
  output logic        out_ras_push,
  output logic        out_ras_pop
);
  localparam int NSLOTS = 2;

  // reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_chain[SYNC_STAGES-1];

  // per-slot decode
  logic [31:0] words [NSLOTS];
  dec_t        decs  [NSLOTS];
  assign words[0] = slot0_insn;
  assign words[1] = slot1_insn;

  for (genvar s = 0; s < NSLOTS; s++) begin : g_dec
    rvfuse_decode u_dec (.insn(words[s]), .dec(decs[s]));
  end

  logic            fuse;
  logic [XLEN-1:0] f_target;
  logic [XLEN-1:0] f_link;
  ras_hint_t       hint;

  rvfuse_match #(.CALL_REG(CALL_REG)) u_match (
    .dec0(decs[0]), .dec1(decs[1]),
    .valid0(slot0_valid), .valid1(slot1_valid), .exc0(slot0_exc),
    .pc0(slot0_pc), .fuse(fuse), .target(f_target), .link(f_link)
  );

  rvfuse_ras #(.LINK_A(LINK_A), .LINK_B(LINK_B)) u_ras (
    .dec(decs[0]), .fuse(fuse), .hint(hint)
  );

  // next-state
  logic            nx_fused;
  logic [31:0]     nx_insn;
  logic [XLEN-1:0] nx_target;
  logic [XLEN-1:0] nx_link;
  logic [4:0]      nx_rd;
  logic            load_en;

  always_comb begin
    load_en   = slot0_valid;
    nx_fused  = fuse;
    nx_insn   = slot0_insn;
    nx_target = fuse ? f_target : '0;
    nx_link   = fuse ? f_link : (slot0_pc + XLEN'(4));
    nx_rd     = fuse ? REG_W'(CALL_REG) : decs[0].rd;
    if (!slot0_valid) take = 2'd0;
    else if (fuse)    take = 2'd2;
    else              take = 2'd1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) out_valid <= 1'b0;
    else          out_valid <= slot0_valid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_fused    <= 1'b0;
      out_insn     <= '0;
      out_pc       <= '0;
      out_exc      <= 1'b0;
      out_target   <= '0;
      out_link     <= '0;
      out_rd       <= '0;
      out_ras_push <= 1'b0;
      out_ras_pop  <= 1'b0;
    end else if (load_en) begin
      out_fused    <= nx_fused;
      out_insn     <= nx_insn;
      out_pc       <= slot0_pc;
      out_exc      <= slot0_exc;
      out_target   <= nx_target;
      out_link     <= nx_link;
      out_rd       <= nx_rd;
      out_ras_push <= hint.push;
      out_ras_pop  <= hint.pop;
    end
  end
endmodule

// File: rtl/rvfuse_call_chk.sv
module rvfuse_call_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        slot0_valid,
  input logic        slot0_exc,
  input logic        slot1_valid,
  input logic [1:0]  take,
  input logic        out_valid,
  input logic        out_fused,
  input logic [31:0] out_pc,
  input logic [31:0] out_target,
  input logic [31:0] out_link,
  input logic [4:0]  out_rd,
  input logic        out_ras_push,
  input logic        out_ras_pop
);
  // R2
  pair_fuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take == 2'd2) |=> (out_valid && out_fused));

  // R7
  fuse_needs_clean_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take == 2'd2) |-> (slot0_valid && slot1_valid && !slot0_exc));

  // R3
  target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> (out_target[0] == 1'b0));

  // R4
  fused_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> ((out_link == out_pc + 32'd8) && (out_rd == 5'd1)));

  // R5
  fused_push_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> (out_ras_push && !out_ras_pop));

  // R11
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot0_valid |=> !out_valid);

  // R11
  idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot0_valid |-> (take == 2'd0));
endmodule

bind rvfuse_call rvfuse_call_chk u_chk (
  .clk(clk), .rst_n(rst_q_n),
  .slot0_valid(slot0_valid), .slot0_exc(slot0_exc), .slot1_valid(slot1_valid),
  .take(take), .out_valid(out_valid), .out_fused(out_fused), .out_pc(out_pc),
  .out_target(out_target), .out_link(out_link), .out_rd(out_rd),
  .out_ras_push(out_ras_push), .out_ras_pop(out_ras_pop)
);

// File: tb/rvfuse_call_bench.sv
`timescale 1ns/1ps
module rvfuse_call_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot0_valid, slot0_exc, slot1_valid;
  logic [31:0] slot0_insn, slot0_pc, slot1_insn;
  logic [1:0]  take;
  logic        out_valid, out_fused, out_exc, out_ras_push, out_ras_pop;
  logic [31:0] out_insn, out_pc, out_target, out_link;
  logic [4:0]  out_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rvfuse_call u_rvfuse_call (
    .clk(clk), .rst_n(rst_n),
    .slot0_valid(slot0_valid), .slot0_insn(slot0_insn), .slot0_pc(slot0_pc),
    .slot0_exc(slot0_exc), .slot1_valid(slot1_valid), .slot1_insn(slot1_insn),
    .take(take), .out_valid(out_valid), .out_fused(out_fused), .out_insn(out_insn),
    .out_pc(out_pc), .out_exc(out_exc), .out_target(out_target), .out_link(out_link),
    .out_rd(out_rd), .out_ras_push(out_ras_push), .out_ras_pop(out_ras_pop)
  );

  function automatic logic [31:0] mk_upc(input logic [4:0] rd, input logic [19:0] imm);
    return {imm, rd, 7'b0010111};
  endfunction
  function automatic logic [31:0] mk_jr(input logic [4:0] rd, input logic [4:0] rs1,
                                        input logic [11:0] imm, input logic [2:0] f3);
    return {imm, rs1, f3, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] mk_j(input logic [4:0] rd);
    return {20'h00010, rd, 7'b1101111};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, take sampled 1ns later, registered outputs 1ns after next posedge
  task automatic present(input bit v0, input logic [31:0] i0, input logic [31:0] pc,
                         input bit e0, input bit v1, input logic [31:0] i1);
    @(negedge clk);
    slot0_valid = v0; slot0_insn = i0; slot0_pc = pc; slot0_exc = e0;
    slot1_valid = v1; slot1_insn = i1;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk(out_fused == 1'b0, "R1 out_fused", {31'b0, out_fused}, 32'd0);
    chk(take == 2'd0, "R1 take", {30'b0, take}, 32'd0);
  endtask

  task automatic t_fuse(input logic [31:0] pc, input logic [19:0] hi, input logic [11:0] lo);
    logic [31:0] exp_t;
    exp_t = (pc + {hi, 12'h000} + {{20{lo[11]}}, lo}) & 32'hFFFF_FFFE;
    present(1, mk_upc(5'd1, hi), pc, 0, 1, mk_jr(5'd1, 5'd1, lo, 3'b000));
    chk(take == 2'd2, "R2 take", {30'b0, take}, 32'd2);
    after_edge();
    chk(out_valid && out_fused, "R2 fused", {30'b0, out_valid, out_fused}, 32'd3);
    chk(out_target == exp_t, "R3 target", out_target, exp_t);
    chk(out_link == pc + 32'd8, "R4 link", out_link, pc + 32'd8);
    chk(out_rd == 5'd1, "R4 rd", {27'b0, out_rd}, 32'd1);
    chk(out_ras_push && !out_ras_pop, "R5 hint", {30'b0, out_ras_push, out_ras_pop}, 32'd2);
  endtask

  task automatic t_nofuse(input logic [31:0] i0, input logic [31:0] i1, input bit v1,
                          input bit e0, input string req);
    logic [31:0] pc;
    pc = 32'h0000_2000;
    present(1, i0, pc, e0, v1, i1);
    chk(take == 2'd1, req, {30'b0, take}, 32'd1);
    after_edge();
    chk(out_valid && !out_fused, req, {30'b0, out_valid, out_fused}, 32'd2);
    chk(out_insn == i0, "R8 insn", out_insn, i0);
    chk(out_pc == pc, "R8 pc", out_pc, pc);
    chk(out_link == pc + 32'd4, "R8 link", out_link, pc + 32'd4);
    chk(out_rd == i0[11:7], "R8 rd", {27'b0, out_rd}, {27'b0, i0[11:7]});
    chk(out_target == 32'd0, "R8 target", out_target, 32'd0);
    chk(out_exc == e0, "R7 exc", {31'b0, out_exc}, {31'b0, e0});
  endtask

  task automatic t_hint(input logic [31:0] i0, input bit push, input bit pop, input string req);
    present(1, i0, 32'h0000_3000, 0, 0, 32'd0);
    after_edge();
    chk(out_ras_push == push && out_ras_pop == pop, req,
        {30'b0, out_ras_push, out_ras_pop}, {30'b0, push, pop});
  endtask

  task automatic t_idle();
    present(0, mk_upc(5'd1, 20'h1), 32'h0, 0, 1, mk_jr(5'd1, 5'd1, 12'h0, 3'b000));
    chk(take == 2'd0, "R11 take", {30'b0, take}, 32'd0);
    after_edge();
    chk(out_valid == 1'b0, "R11 out_valid", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    slot0_valid = 0; slot0_insn = 0; slot0_pc = 0; slot0_exc = 0;
    slot1_valid = 0; slot1_insn = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();

    t_fuse(32'h0000_1000, 20'h12345, 12'h678);
    t_fuse(32'h8000_0004, 20'h00001, 12'hFFF);
    t_fuse(32'h0000_0010, 20'hFFFFF, 12'h801);

    t_nofuse(mk_upc(5'd7, 20'h10), mk_jr(5'd1, 5'd7, 12'h4, 3'b000), 1, 0, "R6 scratch idiom");
    t_nofuse(mk_upc(5'd5, 20'h10), mk_jr(5'd5, 5'd5, 12'h4, 3'b000), 1, 0, "R6 x5 pair");
    t_nofuse(mk_upc(5'd1, 20'h10), mk_jr(5'd1, 5'd1, 12'h4, 3'b001), 1, 0, "R6 funct3");
    t_nofuse(mk_upc(5'd1, 20'h10), mk_jr(5'd6, 5'd1, 12'h4, 3'b000), 1, 0, "R6 rd mismatch");
    t_nofuse(mk_upc(5'd1, 20'h10), mk_jr(5'd1, 5'd1, 12'h4, 3'b000), 0, 0, "R7 slot1 invalid");
    t_nofuse(mk_upc(5'd1, 20'h10), mk_jr(5'd1, 5'd1, 12'h4, 3'b000), 1, 1, "R7 exception");

    t_hint(mk_jr(5'd6, 5'd7, 12'h0, 3'b000), 0, 0, "R9 none");
    t_hint(mk_jr(5'd6, 5'd1, 12'h0, 3'b000), 0, 1, "R9 pop");
    t_hint(mk_jr(5'd1, 5'd7, 12'h0, 3'b000), 1, 0, "R9 push");
    t_hint(mk_jr(5'd1, 5'd5, 12'h0, 3'b000), 1, 1, "R9 push and pop");
    t_hint(mk_jr(5'd5, 5'd5, 12'h0, 3'b000), 1, 0, "R9 push only same");
    t_hint(mk_j(5'd1), 1, 0, "R10 jal link");
    t_hint(mk_j(5'd0), 0, 0, "R10 jal x0");
    t_hint(mk_upc(5'd1, 20'h5), 0, 0, "R10 other opcode");

    t_idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule